// File: doc/BRIEF.md
# Per-Channel Extremes Tracker with Latched Limit Alarms

This block sits behind a multi-channel converter and watches its stream of results. Each result arrives as one valid cycle carrying a channel number and a 16-bit value. The block keeps a running highest and lowest value for every channel. It also tests each result against that channel's own upper and lower limit, so software learns of a limit breach without filtering samples itself.

A breach sets a status bit that stays set until software writes a one to that bit position. A mask register selects which status bits drive the interrupt line. Software reaches all of this through a plain register port. A read returns its data one cycle after the request, marked by a valid strobe. The read side is a two-state machine. `RP_IDLE` moves to `RP_RESP` when a read is requested. `RP_RESP` stays in `RP_RESP` while reads keep coming, and returns to `RP_IDLE` when they stop.

Register map for the default of four channels: a per-channel register sits at address `c*4 + f`. The field `f` is 0 for highest (read-only), 1 for lowest (read-only), 2 for upper limit and 3 for lower limit. The status register is at address 16 and the mask register at address 17.

Top module: `mmtrk_top`

## Requirements
- R1: After reset, every highest register reads 0x0000, every lowest register reads 0xFFFF, every upper limit reads 0xFFFF, every lower limit reads 0x0000, status and mask read 0, and `irq` is low.
- R2: A valid sample raises the highest register of its own channel when its value is larger, and lowers the lowest register when its value is smaller. No other channel's registers change.
- R3: Reading the highest or lowest registers does not clear them, and writes to those addresses are ignored. Only reset returns them to their initial values.
- R4: A sample strictly above its channel's upper limit sets status bit 2c. A sample strictly below the lower limit sets status bit 2c+1. A sample equal to a limit sets nothing.
- R5: Status bits stay set after later in-range samples.
- R6: Writing the status register clears exactly the bits written as one. Bits written as zero are unchanged.
- R7: If a breach and a clearing write for the same bit fall in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some status bit is set and its mask bit (same position as in status) is one.
- R9: A read request in one cycle yields `reg_rvalid` and the register's value in the next cycle. The value is the one held before that request's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_ch | input | CH_W (2) | Channel number of the sample |
| smp_data | input | DATA_W (16) | Sample value, unsigned |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (5) | Register address |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | 1 | OR of set and unmasked status bits |

## Verification
The hardest situation to reach from the ports is a new breach that lands on the same clock edge as a software write clearing that same status bit. Only that timing shows whether the clear or the set wins. The bench drives a sample above the upper limit and a one-to-clear write to the matching bit in a single cycle, then reads status back. It also checks that an in-range sample in a clearing cycle leaves the bit clear, and that samples equal to a limit set nothing.

// File: rtl/mmtrk_pkg.sv
package mmtrk_pkg;
    typedef enum logic [1:0] {
        FLD_MAX = 2'd0,
        FLD_MIN = 2'd1,
        FLD_HI  = 2'd2,
        FLD_LO  = 2'd3
    } chan_fld_e;

    typedef enum logic [0:0] {
        RP_IDLE = 1'b0,
        RP_RESP = 1'b1
    } rport_state_e;
endpackage

// File: rtl/mmtrk_channel.sv
module mmtrk_channel #(
    parameter int DATA_W = 16,
    parameter int CH_W   = 2,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_ch,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] max_q,
    output logic [DATA_W-1:0] min_q,
    output logic [DATA_W-1:0] hi_q,
    output logic [DATA_W-1:0] lo_q,
    output logic              brk_hi,
    output logic              brk_lo
);
    logic hit;

    assign hit    = smp_valid && (smp_ch == CH_W'(CH_IDX));
    assign brk_hi = hit && (smp_data > hi_q);
    assign brk_lo = hit && (smp_data < lo_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q <= '0;
            min_q <= '1;
        end else if (hit) begin
            if (smp_data > max_q) max_q <= smp_data;
            if (smp_data < min_q) min_q <= smp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '1;
            lo_q <= '0;
        end else begin
            if (wr_hi) hi_q <= wdata;
            if (wr_lo) lo_q <= wdata;
        end
    end
endmodule

// File: rtl/mmtrk_alarm.sv
module mmtrk_alarm #(
    parameter int ALM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALM_W-1:0] set_vec,
    input  logic [ALM_W-1:0] clr_vec,
    input  logic             mask_wr,
    input  logic [ALM_W-1:0] mask_wdata,
    output logic [ALM_W-1:0] status_q,
    output logic [ALM_W-1:0] mask_q,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/mmtrk_regport.sv
module mmtrk_regport
    import mmtrk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 5,
    parameter int ALM_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [ALM_W-1:0]         wdata_alm,
    input  logic [NUM_CH*DATA_W-1:0] max_flat,
    input  logic [NUM_CH*DATA_W-1:0] min_flat,
    input  logic [NUM_CH*DATA_W-1:0] hi_flat,
    input  logic [NUM_CH*DATA_W-1:0] lo_flat,
    input  logic [ALM_W-1:0]         status,
    input  logic [ALM_W-1:0]         mask,
    output logic [NUM_CH-1:0]        wr_hi,
    output logic [NUM_CH-1:0]        wr_lo,
    output logic [ALM_W-1:0]         clr_vec,
    output logic                     mask_wr,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     reg_rvalid
);
    rport_state_e state_q, state_d;
    logic             is_glob;
    logic [CH_W-1:0]  ch_sel;
    chan_fld_e        fld;
    logic [DATA_W-1:0] rd_mux;

    assign is_glob = reg_addr[ADDR_W-1];
    assign ch_sel  = reg_addr[CH_W+1:2];
    assign fld     = chan_fld_e'(reg_addr[1:0]);

    assign clr_vec = (reg_wr && is_glob && !reg_addr[0]) ? wdata_alm : '0;
    assign mask_wr = reg_wr && is_glob && reg_addr[0];

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr_hi[c] = reg_wr && !is_glob && (ch_sel == CH_W'(c)) && (fld == FLD_HI);
            wr_lo[c] = reg_wr && !is_glob && (ch_sel == CH_W'(c)) && (fld == FLD_LO);
        end
    end

    always_comb begin
        rd_mux = '0;
        if (is_glob) begin
            if (reg_addr[0]) rd_mux[ALM_W-1:0] = mask;
            else             rd_mux[ALM_W-1:0] = status;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_sel == CH_W'(c)) begin
                    unique case (fld)
                        FLD_MAX: rd_mux = max_flat[c*DATA_W +: DATA_W];
                        FLD_MIN: rd_mux = min_flat[c*DATA_W +: DATA_W];
                        FLD_HI:  rd_mux = hi_flat[c*DATA_W +: DATA_W];
                        FLD_LO:  rd_mux = lo_flat[c*DATA_W +: DATA_W];
                    endcase
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE: if (reg_rd)  state_d = RP_RESP;
            RP_RESP: if (!reg_rd) state_d = RP_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    always_comb begin
        unique case (state_q)
            RP_IDLE: reg_rvalid = 1'b0;
            RP_RESP: reg_rvalid = 1'b1;
        endcase
    end
endmodule

// File: rtl/mmtrk_top.sv
module mmtrk_top #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int ADDR_W = CH_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_ch,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq
);
    localparam int ALM_W = 2 * NUM_CH;

    logic [NUM_CH*DATA_W-1:0] max_flat, min_flat, hi_flat, lo_flat;
    logic [NUM_CH-1:0]        wr_hi, wr_lo;
    logic [ALM_W-1:0]         set_vec, clr_vec, status_q, mask_q;
    logic                     mask_wr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mmtrk_channel #(.DATA_W(DATA_W), .CH_W(CH_W), .CH_IDX(c)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_valid(smp_valid),
            .smp_ch   (smp_ch),
            .smp_data (smp_data),
            .wr_hi    (wr_hi[c]),
            .wr_lo    (wr_lo[c]),
            .wdata    (reg_wdata),
            .max_q    (max_flat[c*DATA_W +: DATA_W]),
            .min_q    (min_flat[c*DATA_W +: DATA_W]),
            .hi_q     (hi_flat[c*DATA_W +: DATA_W]),
            .lo_q     (lo_flat[c*DATA_W +: DATA_W]),
            .brk_hi   (set_vec[2*c]),
            .brk_lo   (set_vec[2*c+1])
        );
    end

    mmtrk_alarm #(.ALM_W(ALM_W)) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .mask_wr   (mask_wr),
        .mask_wdata(reg_wdata[ALM_W-1:0]),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .irq       (irq)
    );

    mmtrk_regport #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W),
        .ADDR_W(ADDR_W), .ALM_W(ALM_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .wdata_alm (reg_wdata[ALM_W-1:0]),
        .max_flat  (max_flat),
        .min_flat  (min_flat),
        .hi_flat   (hi_flat),
        .lo_flat   (lo_flat),
        .status    (status_q),
        .mask      (mask_q),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .clr_vec   (clr_vec),
        .mask_wr   (mask_wr),
        .reg_rdata (reg_rdata),
        .reg_rvalid(reg_rvalid)
    );
endmodule

// File: rtl/mmtrk_checker.sv
module mmtrk_checker #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int CH_W   = 2,
    parameter int ALM_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_valid,
    input logic [CH_W-1:0]          smp_ch,
    input logic [DATA_W-1:0]        smp_data,
    input logic                     reg_rd,
    input logic                     reg_rvalid,
    input logic                     irq,
    input logic [ALM_W-1:0]         status_q,
    input logic [ALM_W-1:0]         mask_q,
    input logic [ALM_W-1:0]         clr_vec,
    input logic [NUM_CH*DATA_W-1:0] max_flat,
    input logic [NUM_CH*DATA_W-1:0] min_flat,
    input logic [NUM_CH*DATA_W-1:0] hi_flat,
    input logic [NUM_CH*DATA_W-1:0] lo_flat
);
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_q) & ~status_q) & ~$past(clr_vec)) == '0)); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R8

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_MAX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
            (max_flat[c*DATA_W +: DATA_W] >= $past(max_flat[c*DATA_W +: DATA_W]))); // R3

        AST_MIN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
            (min_flat[c*DATA_W +: DATA_W] <= $past(min_flat[c*DATA_W +: DATA_W]))); // R3

        AST_HI_BREACH: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && smp_ch == CH_W'(c) && smp_data > hi_flat[c*DATA_W +: DATA_W])
            |=> status_q[2*c]); // R7

        AST_LO_BREACH: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && smp_ch == CH_W'(c) && smp_data < lo_flat[c*DATA_W +: DATA_W])
            |=> status_q[2*c+1]); // R4
    end
endmodule

bind mmtrk_top mmtrk_checker #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W), .ALM_W(2*NUM_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ch    (smp_ch),
    .smp_data  (smp_data),
    .reg_rd    (reg_rd),
    .reg_rvalid(reg_rvalid),
    .irq       (irq),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .clr_vec   (clr_vec),
    .max_flat  (max_flat),
    .min_flat  (min_flat),
    .hi_flat   (hi_flat),
    .lo_flat   (lo_flat)
);

// File: tb/test_mmtrk_top.sv
`timescale 1ns/1ps
module test_mmtrk_top;
    localparam int NCH = 4;
    localparam int STAT_A = 16;
    localparam int MASK_A = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_ch = '0;
    logic [15:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_max [NCH];
    logic [15:0] m_min [NCH];
    logic [15:0] m_hi  [NCH];
    logic [15:0] m_lo  [NCH];
    logic [7:0]  m_stat;
    logic [7:0]  m_mask;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    mmtrk_top i_mmtrk_top (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ch(smp_ch),
        .smp_data(smp_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_reg(input int a);
        if (a == STAT_A) return {8'h00, m_stat};
        if (a == MASK_A) return {8'h00, m_mask};
        case (a % 4)
            0: return m_max[a/4];
            1: return m_min[a/4];
            2: return m_hi[a/4];
            default: return m_lo[a/4];
        endcase
    endfunction

    function automatic logic [7:0] model_set(input int ch, input logic [15:0] d);
        logic [7:0] s = '0;
        if (d > m_hi[ch]) s[2*ch] = 1'b1;
        if (d < m_lo[ch]) s[2*ch+1] = 1'b1;
        return s;
    endfunction

    function automatic void model_sample(input int ch, input logic [15:0] d);
        if (d > m_max[ch]) m_max[ch] = d;
        if (d < m_min[ch]) m_min[ch] = d;
    endfunction

    function automatic void model_write(input int a, input logic [15:0] d);
        if (a == STAT_A)      m_stat = m_stat & ~d[7:0];
        else if (a == MASK_A) m_mask = d[7:0];
        else if (a % 4 == 2)  m_hi[a/4] = d;
        else if (a % 4 == 3)  m_lo[a/4] = d;
    endfunction

    // driver tasks: enter and leave at a falling edge
    task automatic do_sample(input int ch, input logic [15:0] d);
        m_stat = m_stat | model_set(ch, d);
        model_sample(ch, d);
        smp_valid = 1'b1; smp_ch = 2'(ch); smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [15:0] d);
        model_write(a, d);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_sample_and_write(input int ch, input logic [15:0] d,
                                       input int a, input logic [15:0] wd);
        logic [7:0] s;
        s = model_set(ch, d);
        model_write(a, wd);
        model_sample(ch, d);
        m_stat = m_stat | s;
        smp_valid = 1'b1; smp_ch = 2'(ch); smp_data = d;
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = wd;
        @(negedge clk);
        smp_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic do_read(input int a, input string tag);
        exp_q.push_back(model_reg(a));
        tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = 5'(a);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic check_irq(input string tag);
        check(tag, {15'd0, irq}, {15'd0, |(m_stat & m_mask)});
    endtask

    // monitor: scoreboard pop on each returned read
    always @(negedge clk) begin
        if (reg_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected read data 0x%04h expected none", reg_rdata);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_max[c] = 16'h0000; m_min[c] = 16'hFFFF;
            m_hi[c]  = 16'hFFFF; m_lo[c]  = 16'h0000;
        end
        m_stat = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_irq("R1 irq after reset");
        check("R1 rvalid idle", {15'd0, reg_rvalid}, 16'd0);
        do_read(0, "R1 max ch0");
        do_read(1, "R1 min ch0");
        do_read(10, "R1 upper ch2");
        do_read(15, "R1 lower ch3");
        do_read(STAT_A, "R1 status");
        do_read(MASK_A, "R1 mask");

        // R2 running extremes per channel
        do_sample(0, 16'h1000);
        do_sample(0, 16'h3000);
        do_sample(0, 16'h2000);
        do_sample(1, 16'h0500);
        do_read(0, "R2 max ch0");
        do_read(1, "R2 min ch0");
        do_read(4, "R2 max ch1");
        do_read(5, "R2 min ch1");
        do_read(8, "R2 max ch2 untouched");
        do_read(9, "R2 min ch2 untouched");

        // R3 reads do not clear, writes ignored
        do_read(0, "R3 max ch0 reread");
        do_write(0, 16'h1234);
        do_write(1, 16'h1234);
        do_read(0, "R3 max ch0 after write");
        do_read(1, "R3 min ch0 after write");

        // R4 strict limit compare, bit 2c upper, 2c+1 lower
        do_write(6, 16'h0800);
        do_write(7, 16'h0200);
        do_read(6, "R4 upper ch1 readback");
        do_sample(1, 16'h0800);
        do_sample(1, 16'h0200);
        do_read(STAT_A, "R4 equal sets nothing");
        do_sample(1, 16'h0801);
        do_sample(1, 16'h01FF);
        do_read(STAT_A, "R4 breaches ch1");
        do_write(15, 16'h0100);
        do_sample(3, 16'h0050);
        do_read(STAT_A, "R4 lower breach ch3");

        // R5 latched after in-range samples
        do_sample(1, 16'h0400);
        do_sample(3, 16'h0400);
        do_read(STAT_A, "R5 still latched");

        // R6 write one to clear
        do_write(STAT_A, 16'h0084);
        do_read(STAT_A, "R6 cleared bits 2 and 7");
        do_write(STAT_A, 16'h0000);
        do_read(STAT_A, "R6 zero write no effect");

        // R8 interrupt
        check_irq("R8 mask zero");
        do_write(MASK_A, 16'h0004);
        check_irq("R8 masked-in bit clear");
        do_write(MASK_A, 16'h0008);
        check_irq("R8 unmasked bit set");
        do_read(MASK_A, "R8 mask readback");
        do_write(STAT_A, 16'h0008);
        check_irq("R8 after clear");

        // R7 breach and clear in the same cycle
        do_write(MASK_A, 16'h0004);
        do_sample_and_write(1, 16'h0900, STAT_A, 16'h0004);
        check_irq("R7 irq kept");
        do_read(STAT_A, "R7 bit survives clear");
        do_sample_and_write(1, 16'h0400, STAT_A, 16'h0004);
        check_irq("R7 irq dropped");
        do_read(STAT_A, "R7 clear without breach");

        // R9 back-to-back reads, read concurrent with sample
        reg_rd = 1'b1; reg_addr = 5'd4;
        exp_q.push_back(model_reg(4)); tag_q.push_back("R9 back-to-back first");
        @(negedge clk);
        reg_addr = 5'd12;
        exp_q.push_back(model_reg(12)); tag_q.push_back("R9 read old value");
        model_sample(3, 16'h7777);
        m_stat = m_stat | model_set(3, 16'h7777);
        smp_valid = 1'b1; smp_ch = 2'd3; smp_data = 16'h7777;
        @(negedge clk);
        reg_rd = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        check("R9 rvalid drops", {15'd0, reg_rvalid}, 16'd0);
        do_read(12, "R9 new value");
        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R9: actual %0d pending reads expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule